// File: doc/BRIEF.md
# Supervisory Reset Stretcher With Pushbutton

This block drives the processor reset line from two sources. The first is a supply-in-tolerance flag that is already synchronous to the clock. The second is an active-low pushbutton input that arrives asynchronously. A supply drop that lasts long enough asserts the reset and holds it for as long as the drop lasts. Drops shorter than a noise-immunity window are ignored.

A pushbutton press counts only when the button reads low, without a break, across a debounce window. The reset stays asserted for as long as the button is held. Once the supply is back or the button release has been debounced, the reset is held for a fixed stretch so that the supply and the processor can settle. Any new cause of reset that appears during the stretch starts the stretch over.

The reset comes out in two forms, active-low and active-high. A one-cycle strobe marks the cycle in which the reset is released, so that a watchdog can start its timeout from that point. All durations are parameters counted in clock cycles. The block's own power-on reset is treated like an out-of-tolerance supply.

Top module: `sup_reset_stretch`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `release_pulse` is 0. After `rst_n` goes high with no other cause of reset, the reset stays asserted for STRETCH_CYC cycles and is then released.
- R2: `rst_out_n` is always the logical inverse of `rst_out`. A value of 1 on `rst_out` means reset is asserted.
- R3: A run of GLITCH_CYC consecutive clock samples of `supply_ok` = 0 asserts the reset on the clock edge after the sample that completes the run.
- R4: A run of `supply_ok` = 0 shorter than GLITCH_CYC samples has no effect on `rst_out`, `rst_out_n` or `release_pulse`.
- R5: Once asserted by a supply drop, the reset stays asserted while `supply_ok` stays 0. After `supply_ok` returns to 1, it is released STRETCH_CYC+1 cycles later.
- R6: `btn_n` passes through two synchronizer flops. After that, it must read 0 for DEBOUNCE_CYC consecutive samples to count as a press and 1 for DEBOUNCE_CYC consecutive samples to count as a release. Shorter bounces have no effect on the outputs.
- R7: The reset is asserted for the whole time the button is debounced as pressed. The stretch begins only after the release has been debounced, not when the button is pressed.
- R8: A debounced press, or a qualified supply drop, that occurs during the stretch sends the stretch back to zero. The full STRETCH_CYC count then restarts once that cause clears.
- R9: `release_pulse` is 1 for exactly one cycle. That cycle is the first cycle in which `rst_out` is 0, and the pulse occurs at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block power-on reset, asynchronous, active low |
| supply_ok | input | 1 | Synchronized supply-in-tolerance flag, 1 = in tolerance |
| btn_n | input | 1 | Asynchronous pushbutton input, 0 = pressed |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| release_pulse | output | 1 | One-cycle strobe in the cycle the reset is released |

## Verification
The hardest case to reach from the ports is a new cause of reset that lands in the last few cycles of a stretch. Close behind it are a bounce or a supply dip exactly one sample shorter than its qualifying window. The bench reaches both with directed sequences, timed from the cycle-accurate model's view of the stretch count. It then runs a long phase of pseudo-random button and supply activity, whose run lengths cluster around the debounce and glitch limits. The model is compared with every output on every cycle.

// File: rtl/sup_reset_stretch.sv
module sup_reset_stretch #(
  parameter int DEBOUNCE_CYC = 1_250_000,
  parameter int GLITCH_CYC   = 250,
  parameter int STRETCH_CYC  = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic btn_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic release_pulse
);
  localparam int DW = $clog2(DEBOUNCE_CYC + 1);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEBOUNCE_CYC - 1);
  localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);
  localparam logic [SW-1:0] S_LAST = SW'(STRETCH_CYC - 1);

  logic [1:0]    bsync;
  logic [DW-1:0] dcnt;
  logic [GW-1:0] gcnt;
  logic [SW-1:0] scnt;
  logic          pressed, fault, active, rel_q;
  logic          raw_press, hold, done;

  assign raw_press = ~bsync[1];
  assign hold      = fault | pressed;
  assign done      = active & ~hold & (scnt == S_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bsync <= 2'b11;
    else        bsync <= {bsync[0], btn_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt    <= '0;
      pressed <= 1'b0;
    end else if (raw_press == pressed) begin
      dcnt <= '0;
    end else if (dcnt == D_LAST) begin
      dcnt    <= '0;
      pressed <= raw_press;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gcnt  <= '0;
      fault <= 1'b0;
    end else if (supply_ok) begin
      gcnt  <= '0;
      fault <= 1'b0;
    end else if (gcnt == G_LAST) begin
      fault <= 1'b1;
    end else begin
      gcnt <= gcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scnt   <= '0;
      active <= 1'b1;
      rel_q  <= 1'b0;
    end else begin
      rel_q <= done;
      if (hold) begin
        scnt   <= '0;
        active <= 1'b1;
      end else if (done) begin
        active <= 1'b0;
      end else if (active) begin
        scnt <= scnt + 1'b1;
      end
    end

  assign rst_out       = active;
  assign rst_out_n     = ~active;
  assign release_pulse = rel_q;

  a_r3_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> active);

  a_r8_hold_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (active && scnt == '0));

  a_r9_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> $fell(active));

  a_r9_fall_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> release_pulse);

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);

  a_r6_press_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> $past(raw_press));
endmodule

// File: tb/sup_reset_stretch_test.sv
module sup_reset_stretch_test;
  localparam int DEB = 8;
  localparam int GL  = 4;
  localparam int STR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic btn_n = 1'b1;
  logic rst_out_n, rst_out, release_pulse;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sup_reset_stretch #(.DEBOUNCE_CYC(DEB), .GLITCH_CYC(GL), .STRETCH_CYC(STR)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .release_pulse(release_pulse));

  // Behavioural reference model: run lengths, not state registers
  int b_pipe[$];
  int btn_low_run, btn_high_run, sup_low_run;
  bit m_pressed, m_fault, m_active, m_rel;
  int m_count;

  task automatic model_reset();
    b_pipe = {1, 1};
    btn_low_run = 0; btn_high_run = 0; sup_low_run = 0;
    m_pressed = 0; m_fault = 0; m_active = 1; m_rel = 0; m_count = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      automatic int seen = b_pipe.pop_front();
      automatic bit cause = m_fault || m_pressed;
      b_pipe.push_back(int'(btn_n));
      if (seen == 0) begin btn_low_run++; btn_high_run = 0; end
      else begin btn_high_run++; btn_low_run = 0; end
      m_rel = 0;
      if (cause) begin m_active = 1; m_count = 0; end
      else if (m_active) begin
        m_count++;
        if (m_count == STR) begin m_active = 0; m_rel = 1; end
      end
      if (!m_pressed && btn_low_run >= DEB) begin m_pressed = 1; btn_low_run = 0; end
      else if (m_pressed && btn_high_run >= DEB) begin m_pressed = 0; btn_high_run = 0; end
      if (m_pressed) btn_low_run = 0; else btn_high_run = 0;
      if (supply_ok) begin sup_low_run = 0; m_fault = 0; end
      else begin sup_low_run++; if (sup_low_run >= GL) m_fault = 1; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!done_flag) begin
    check(rst_out == m_active, "R5/R7 rst_out vs model", rst_out, m_active);
    check(rst_out_n == !rst_out, "R2 complement", rst_out_n, !rst_out);
    check(release_pulse == m_rel, "R9 strobe vs model", release_pulse, m_rel);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int lfsr = 32'h1ACE;
  initial begin
    cyc(3);
    check(rst_out == 1 && release_pulse == 0, "R1 reset state", rst_out, 1);
    rst_n = 1'b1;
    cyc(STR - 2);
    check(rst_out == 1, "R1 still stretching", rst_out, 1);
    cyc(4);
    check(rst_out == 0, "R1 released after stretch", rst_out, 0);
    // R4: dip one sample short
    supply_ok = 0; cyc(GL - 1); supply_ok = 1; cyc(6);
    check(rst_out == 0, "R4 short dip ignored", rst_out, 0);
    // R3/R5 long dip
    supply_ok = 0; cyc(GL + 1);
    check(rst_out == 1, "R3 long dip asserts", rst_out, 1);
    cyc(15);
    check(rst_out == 1, "R5 held during dip", rst_out, 1);
    supply_ok = 1; cyc(STR);
    check(rst_out == 1, "R5 stretch after return", rst_out, 1);
    cyc(3);
    check(rst_out == 0, "R5 released", rst_out, 0);
    // R6 bounce shorter than debounce
    btn_n = 0; cyc(DEB - 1); btn_n = 1; cyc(10);
    check(rst_out == 0, "R6 bounce ignored", rst_out, 0);
    // R7 real press, stretch from release
    btn_n = 0; cyc(DEB + 40);
    check(rst_out == 1, "R7 held while pressed", rst_out, 1);
    btn_n = 1; cyc(DEB + STR - 2);
    check(rst_out == 1, "R7 stretch from release", rst_out, 1);
    cyc(8);
    check(rst_out == 0, "R7 released", rst_out, 0);
    // R8 restart late in stretch
    supply_ok = 0; cyc(GL + 2); supply_ok = 1;
    cyc(STR - 3);
    supply_ok = 0; cyc(GL + 1); supply_ok = 1;
    cyc(STR - 2);
    check(rst_out == 1, "R8 stretch restarted", rst_out, 1);
    cyc(6);
    check(rst_out == 0, "R8 released after restart", rst_out, 0);
    // random runs clustered around the windows
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 3) supply_ok = ~supply_ok;
      if (lfsr[7:4] < 2) btn_n = ~btn_n;
      cyc(1 + int'(lfsr[10:8]));
    end
    supply_ok = 1; btn_n = 1; cyc(DEB + STR + GL + 10);
    check(rst_out == 0, "R9 final release", rst_out, 0);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule